// File: doc/BRIEF.md
# Register write-pending scoreboard

The block keeps one pending bit per architectural register of a register file. A bit is raised when an instruction is issued to an execution unit and that instruction will write the register. It drops when the register file write for that register is granted. While a bit is up, any newly issuing instruction that reads the register sees a read-after-write hazard on a combinational output, and the issue logic holds it back.

Each execution unit also captures, at issue, whether its instruction intends to write and which register it targets. A unit can finish without producing a result, shown by `done` with the result-valid flag low. In that case the captured intent clears the pending bit on the unit's behalf, because no write will ever arrive to clear it. Units configured as load/store units never use this path and are assumed always to write.

Register addresses on every port are either binary indices or one-hot masks. The choice is made at elaboration time through the `MODE` parameter, and the address width follows from it. All requester enables on one port are OR-reduced into a single mask before they reach the storage.

Top module: `wpend_board`

## Requirements
- R1: After reset every pending bit is zero and `hazard_o` is low. Bit n of `pend_o` is the pending flag of register n.
- R2: On a clock edge where `iss_valid_i`, at least one bit of `iss_unit_i` and `iss_wr_i` are all high, the bit for `iss_dst_i` is set. If any one of the three is low, no bit is set.
- R3: On a clock edge where `wr_grant_i[u]` is high, the bit addressed by unit u's field `wr_addr_i[u*AW +: AW]` is cleared. The address field of a unit whose grant is low has no effect.
- R4: If a set and a clear hit the same bit on the same edge, the bit ends up set.
- R5: `hazard_o` is combinational. It is the OR of the pending bits of every source field `chk_src_i[s*AW +: AW]` whose `chk_rd_i[s]` is high, and only while `chk_en_i` is high. A source whose read flag is low does not contribute.
- R6: A unit that was issued with `iss_wr_i` high and then raises `fu_done_i` with `fu_res_ok_i` low clears the pending bit of its captured destination on that edge.
- R7: Done with `fu_res_ok_i` high leaves the pending bit set, so it waits for the granted write.
- R8: A unit's captured write intent is reset on any edge where its `fu_busy_i` is low and it is not being issued. A later done without result then clears nothing.
- R9: Units marked in `LDST_UNITS` (by default the highest-numbered unit) never clear a bit on done without result.
- R10: Grants from several units on one edge clear all of their addressed bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid_i | input | 1 | Issue strobe |
| iss_unit_i | input | NUNITS | Unit selected for the issuing instruction |
| iss_wr_i | input | 1 | Decoded flag: instruction writes a register |
| iss_dst_i | input | AW | Destination register address |
| chk_en_i | input | 1 | Enables the hazard check for the issuing instruction |
| chk_rd_i | input | NSRC | Per-source read flags |
| chk_src_i | input | NSRC*AW | Packed source register addresses |
| wr_grant_i | input | NUNITS | Register file write grant per unit |
| wr_addr_i | input | NUNITS*AW | Packed write address per unit |
| fu_busy_i | input | NUNITS | Unit busy flags |
| fu_done_i | input | NUNITS | Unit completion strobes |
| fu_res_ok_i | input | NUNITS | Unit result-valid flags |
| hazard_o | output | 1 | Read-after-write hazard for the checked sources |
| pend_o | output | NREGS | Pending-write bit vector |

## Verification
The hardest case to reach is completion without a result: the intent captured at issue must still be held when `done` arrives, and that depends on the unit's busy history since issue. The stimulus issues a writing instruction with busy held high, then raises done with result-valid low. It repeats the same sequence with a one-cycle busy gap before done, and again on a load/store unit, and compares the pending vector after each. The case where a set and a clear land on one bit in one edge is reached by driving the issue and a grant with the same address in one cycle.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

  // How register addresses are presented on every port
  typedef enum logic {
    ADDR_BINARY = 1'b0,
    ADDR_ONEHOT = 1'b1
  } addr_mode_e;

  // Width of one address field for a given register count and mode
  function automatic int unsigned addr_width(int unsigned nregs, addr_mode_e mode);
    if (mode == ADDR_ONEHOT) return nregs;
    if (nregs <= 2) return 1;
    return $clog2(nregs);
  endfunction

endpackage

// File: rtl/wpb_decode.sv
// Turns one address field into a register mask, gated by an enable.
module wpb_decode #(
  parameter int unsigned          NREGS = 32,
  parameter wpb_pkg::addr_mode_e  MODE  = wpb_pkg::ADDR_BINARY,
  parameter int unsigned          AW    = wpb_pkg::addr_width(NREGS, MODE)
) (
  input  logic             gate_i,
  input  logic [AW-1:0]    addr_i,
  output logic [NREGS-1:0] mask_o
);
  generate
    if (MODE == wpb_pkg::ADDR_ONEHOT) begin : g_onehot
      always_comb mask_o = gate_i ? addr_i : '0;
    end else begin : g_binary
      for (genvar i = 0; i < NREGS; i++) begin : g_bit
        assign mask_o[i] = gate_i && (addr_i == AW'(i));
      end
    end
  endgenerate
endmodule

// File: rtl/wpb_intent.sv
// Per-unit capture of write intent and destination at issue; produces the
// clear mask used when the unit finishes without a result.
module wpb_intent #(
  parameter int unsigned          NREGS  = 32,
  parameter wpb_pkg::addr_mode_e  MODE   = wpb_pkg::ADDR_BINARY,
  parameter int unsigned          AW     = wpb_pkg::addr_width(NREGS, MODE),
  parameter bit                   EXEMPT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    dst_i,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic             res_ok_i,
  output logic [NREGS-1:0] nowr_mask_o,
  output logic             intent_o
);
  logic          intent_q;
  logic [AW-1:0] dst_q;
  logic          nowr_fire;

  // Idle resets the intent; an issue in the same cycle takes precedence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intent_q <= 1'b0;
      dst_q    <= '0;
    end else begin
      if (!busy_i) intent_q <= 1'b0;
      if (issue_i) begin
        intent_q <= wr_i;
        dst_q    <= dst_i;
      end
    end
  end

  assign nowr_fire = done_i && intent_q && !res_ok_i && !EXEMPT;
  assign intent_o  = intent_q;

  wpb_decode #(.NREGS(NREGS), .MODE(MODE), .AW(AW)) u_dec (
    .gate_i (nowr_fire),
    .addr_i (dst_q),
    .mask_o (nowr_mask_o)
  );

  p_intent_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && !issue_i) |=> !intent_q);

  p_intent_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> (intent_q == $past(wr_i)));

  p_res_ok_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && res_ok_i) |-> (nowr_mask_o == '0));
endmodule

// File: rtl/wpb_store.sv
// Pending-bit storage; set has priority over clear.
module wpb_store #(
  parameter int unsigned NREGS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREGS-1:0] set_i,
  input  logic [NREGS-1:0] clr_i,
  output logic [NREGS-1:0] pend_o
);
  logic [NREGS-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & clr_i)) |=> ((pend_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));

  p_clear_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

  p_untouched_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend_q ^ $past(pend_q)) & ~$past(set_i | clr_i)) == '0));
endmodule

// File: rtl/wpend_board.sv
module wpend_board #(
  parameter int unsigned          NREGS      = 32,
  parameter wpb_pkg::addr_mode_e  MODE       = wpb_pkg::ADDR_BINARY,
  parameter int unsigned          NUNITS     = 3,
  parameter int unsigned          NSRC       = 3,
  parameter logic [NUNITS-1:0]    LDST_UNITS = {1'b1, {(NUNITS-1){1'b0}}},
  localparam int unsigned         AW         = wpb_pkg::addr_width(NREGS, MODE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iss_valid_i,
  input  logic [NUNITS-1:0]    iss_unit_i,
  input  logic                 iss_wr_i,
  input  logic [AW-1:0]        iss_dst_i,
  input  logic                 chk_en_i,
  input  logic [NSRC-1:0]      chk_rd_i,
  input  logic [NSRC*AW-1:0]   chk_src_i,
  input  logic [NUNITS-1:0]    wr_grant_i,
  input  logic [NUNITS*AW-1:0] wr_addr_i,
  input  logic [NUNITS-1:0]    fu_busy_i,
  input  logic [NUNITS-1:0]    fu_done_i,
  input  logic [NUNITS-1:0]    fu_res_ok_i,
  output logic                 hazard_o,
  output logic [NREGS-1:0]     pend_o
);
  // Per-requester masks before OR-reduction, brought out as named wires
  logic [NREGS-1:0] set_u  [NUNITS];
  logic [NREGS-1:0] grnt_u [NUNITS];
  logic [NREGS-1:0] nowr_u [NUNITS];
  logic [NREGS-1:0] chk_s  [NSRC];
  logic [NUNITS-1:0] intent_u;

  logic [NREGS-1:0] set_mask;
  logic [NREGS-1:0] clr_mask;
  logic [NREGS-1:0] chk_mask;
  logic [NREGS-1:0] pend_q;

  generate
    for (genvar u = 0; u < NUNITS; u++) begin : g_unit
      logic issue_u;
      assign issue_u = iss_valid_i && iss_unit_i[u];

      wpb_decode #(.NREGS(NREGS), .MODE(MODE), .AW(AW)) u_set_dec (
        .gate_i (issue_u && iss_wr_i),
        .addr_i (iss_dst_i),
        .mask_o (set_u[u])
      );

      wpb_decode #(.NREGS(NREGS), .MODE(MODE), .AW(AW)) u_grant_dec (
        .gate_i (wr_grant_i[u]),
        .addr_i (wr_addr_i[u*AW +: AW]),
        .mask_o (grnt_u[u])
      );

      wpb_intent #(.NREGS(NREGS), .MODE(MODE), .AW(AW),
                   .EXEMPT(LDST_UNITS[u])) u_intent (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (issue_u),
        .wr_i        (iss_wr_i),
        .dst_i       (iss_dst_i),
        .busy_i      (fu_busy_i[u]),
        .done_i      (fu_done_i[u]),
        .res_ok_i    (fu_res_ok_i[u]),
        .nowr_mask_o (nowr_u[u]),
        .intent_o    (intent_u[u])
      );

      if (LDST_UNITS[u]) begin : g_ldst_chk
        p_ldst_no_nowr_r9: assert property (@(posedge clk) disable iff (!rst_n)
          (fu_done_i[u] && !fu_res_ok_i[u] && intent_u[u]) |-> (nowr_u[u] == '0));
      end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
      wpb_decode #(.NREGS(NREGS), .MODE(MODE), .AW(AW)) u_chk_dec (
        .gate_i (chk_en_i && chk_rd_i[s]),
        .addr_i (chk_src_i[s*AW +: AW]),
        .mask_o (chk_s[s])
      );
    end
  endgenerate

  // OR-reduction of all requesters on each port
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    for (int u = 0; u < NUNITS; u++) begin
      set_mask = set_mask | set_u[u];
      clr_mask = clr_mask | grnt_u[u] | nowr_u[u];
    end
  end

  always_comb begin
    chk_mask = '0;
    for (int s = 0; s < NSRC; s++) chk_mask = chk_mask | chk_s[s];
  end

  wpb_store #(.NREGS(NREGS)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_mask),
    .clr_i  (clr_mask),
    .pend_o (pend_q)
  );

  assign pend_o   = pend_q;
  assign hazard_o = |(pend_q & chk_mask);

  p_no_check_no_hazard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en_i |-> !hazard_o);

  p_no_pend_no_hazard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> !hazard_o);

  p_quiet_no_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_valid_i || !iss_wr_i) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: tb/wpend_board_bench.sv
module wpend_board_bench;
  localparam int NREGS  = 32;
  localparam int NUNITS = 3;
  localparam int NSRC   = 3;
  localparam int AW     = 5;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 iss_valid_i;
  logic [NUNITS-1:0]    iss_unit_i;
  logic                 iss_wr_i;
  logic [AW-1:0]        iss_dst_i;
  logic                 chk_en_i;
  logic [NSRC-1:0]      chk_rd_i;
  logic [NSRC*AW-1:0]   chk_src_i;
  logic [NUNITS-1:0]    wr_grant_i;
  logic [NUNITS*AW-1:0] wr_addr_i;
  logic [NUNITS-1:0]    fu_busy_i;
  logic [NUNITS-1:0]    fu_done_i;
  logic [NUNITS-1:0]    fu_res_ok_i;
  logic                 hazard_o;
  logic [NREGS-1:0]     pend_o;

  int checks = 0;
  int errors = 0;
  logic [NREGS-1:0] exp_pend;

  always #5 clk = ~clk;

  wpend_board u_wpend_board (
    .clk(clk), .rst_n(rst_n),
    .iss_valid_i(iss_valid_i), .iss_unit_i(iss_unit_i), .iss_wr_i(iss_wr_i),
    .iss_dst_i(iss_dst_i), .chk_en_i(chk_en_i), .chk_rd_i(chk_rd_i),
    .chk_src_i(chk_src_i), .wr_grant_i(wr_grant_i), .wr_addr_i(wr_addr_i),
    .fu_busy_i(fu_busy_i), .fu_done_i(fu_done_i), .fu_res_ok_i(fu_res_ok_i),
    .hazard_o(hazard_o), .pend_o(pend_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    iss_valid_i = 0; iss_unit_i = '0; iss_wr_i = 0; iss_dst_i = '0;
    chk_en_i = 0; chk_rd_i = '0; chk_src_i = '0;
    wr_grant_i = '0; wr_addr_i = '0;
    fu_done_i = '0; fu_res_ok_i = '0;
  endtask

  // inputs already driven; pass one rising edge and return at the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_issue(input int unit, input int dst, input logic wr);
    iss_valid_i = 1; iss_unit_i = NUNITS'(1 << unit); iss_wr_i = wr; iss_dst_i = AW'(dst);
    tick();
    idle();
  endtask

  task automatic do_grant(input int unit, input int addr);
    wr_grant_i = NUNITS'(1 << unit);
    wr_addr_i[unit*AW +: AW] = AW'(addr);
    tick();
    idle();
  endtask

  task automatic t_reset();
    check("R1 pend after reset", 64'(pend_o), 64'(0));
    chk_en_i = 1; chk_rd_i = '1; chk_src_i = {AW'(3), AW'(2), AW'(1)};
    #1 check("R1 hazard after reset", 64'(hazard_o), 64'(0));
    idle();
  endtask

  task automatic t_set();
    do_issue(0, 5, 1'b1);
    exp_pend[5] = 1'b1;
    check("R2 set on issue", 64'(pend_o), 64'(exp_pend));
    do_issue(0, 7, 1'b0);
    check("R2 no set without write flag", 64'(pend_o), 64'(exp_pend));
    iss_valid_i = 1; iss_unit_i = '0; iss_wr_i = 1; iss_dst_i = AW'(9);
    tick(); idle();
    check("R2 no set without unit select", 64'(pend_o), 64'(exp_pend));
    iss_valid_i = 0; iss_unit_i = 3'b001; iss_wr_i = 1; iss_dst_i = AW'(9);
    tick(); idle();
    check("R2 no set without strobe", 64'(pend_o), 64'(exp_pend));
  endtask

  task automatic t_hazard();
    chk_en_i = 1; chk_rd_i = 3'b111; chk_src_i = {AW'(0), AW'(3), AW'(5)};
    #1 check("R5 hazard on pending source", 64'(hazard_o), 64'(1));
    chk_rd_i = 3'b110;
    #1 check("R5 read flag low masks source", 64'(hazard_o), 64'(0));
    chk_src_i = {AW'(5), AW'(3), AW'(0)};
    #1 check("R5 hazard from third source", 64'(hazard_o), 64'(1));
    chk_en_i = 0;
    #1 check("R5 check disabled", 64'(hazard_o), 64'(0));
    idle();
  endtask

  task automatic t_clear();
    wr_addr_i[1*AW +: AW] = AW'(5);
    tick(); idle();
    check("R3 address without grant ignored", 64'(pend_o), 64'(exp_pend));
    do_grant(1, 5);
    exp_pend[5] = 1'b0;
    check("R3 grant clears", 64'(pend_o), 64'(exp_pend));
  endtask

  task automatic t_set_wins();
    do_issue(0, 10, 1'b1);
    exp_pend[10] = 1'b1;
    iss_valid_i = 1; iss_unit_i = 3'b001; iss_wr_i = 1; iss_dst_i = AW'(10);
    wr_grant_i = 3'b010; wr_addr_i[1*AW +: AW] = AW'(10);
    tick(); idle();
    check("R4 set wins over clear", 64'(pend_o), 64'(exp_pend));
    do_grant(1, 10);
    exp_pend[10] = 1'b0;
    check("R4 later clear", 64'(pend_o), 64'(exp_pend));
  endtask

  task automatic t_multi_grant();
    do_issue(0, 1, 1'b1);
    do_issue(1, 2, 1'b1);
    exp_pend[1] = 1'b1; exp_pend[2] = 1'b1;
    check("R10 two bits pending", 64'(pend_o), 64'(exp_pend));
    wr_grant_i = 3'b011;
    wr_addr_i[0*AW +: AW] = AW'(1);
    wr_addr_i[1*AW +: AW] = AW'(2);
    tick(); idle();
    exp_pend[1] = 1'b0; exp_pend[2] = 1'b0;
    check("R10 simultaneous grants clear both", 64'(pend_o), 64'(exp_pend));
  endtask

  task automatic t_no_write_done();
    do_issue(0, 12, 1'b1);
    exp_pend[12] = 1'b1;
    check("R6 pending before done", 64'(pend_o), 64'(exp_pend));
    fu_done_i = 3'b001; fu_res_ok_i = 3'b000;
    tick(); idle();
    exp_pend[12] = 1'b0;
    check("R6 done without result clears", 64'(pend_o), 64'(exp_pend));
  endtask

  task automatic t_done_with_result();
    do_issue(1, 13, 1'b1);
    exp_pend[13] = 1'b1;
    fu_done_i = 3'b010; fu_res_ok_i = 3'b010;
    tick(); idle();
    check("R7 done with result keeps bit", 64'(pend_o), 64'(exp_pend));
    do_grant(1, 13);
    exp_pend[13] = 1'b0;
    check("R7 write grant clears", 64'(pend_o), 64'(exp_pend));
  endtask

  task automatic t_intent_reset();
    do_issue(0, 14, 1'b1);
    exp_pend[14] = 1'b1;
    fu_busy_i = 3'b110;
    tick();
    fu_busy_i = 3'b111;
    fu_done_i = 3'b001; fu_res_ok_i = 3'b000;
    tick(); idle();
    check("R8 idle drops intent, no clear", 64'(pend_o), 64'(exp_pend));
    do_grant(0, 14);
    exp_pend[14] = 1'b0;
    check("R8 cleanup", 64'(pend_o), 64'(exp_pend));
  endtask

  task automatic t_ldst_exempt();
    do_issue(2, 15, 1'b1);
    exp_pend[15] = 1'b1;
    fu_done_i = 3'b100; fu_res_ok_i = 3'b000;
    tick(); idle();
    check("R9 load/store unit keeps bit", 64'(pend_o), 64'(exp_pend));
    do_grant(2, 15);
    exp_pend[15] = 1'b0;
    check("R9 cleanup", 64'(pend_o), 64'(exp_pend));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    fu_busy_i = 3'b111;
    exp_pend = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_set();
    t_hazard();
    t_clear();
    t_set_wins();
    t_multi_grant();
    t_no_write_done();
    t_done_with_result();
    t_intent_reset();
    t_ldst_exempt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule